// File: doc/BRIEF.md
# HDLC Bit-Serial Transmit Framer

This block turns a stream of bytes from a FIFO into a bit-serial HDLC line signal. It fetches bytes through a ready/valid port that carries an end-of-packet marker. For each packet it sends a complete opening flag, then the data least-significant bit first. A zero is inserted after every run of five ones in the data and check fields. An optional 16-bit frame check sequence follows the data, and a closing flag ends the frame. Between frames the line carries back-to-back flags, and one bit goes out for each baud-enable pulse.

The FIFO may run dry inside a packet, before the end-of-packet byte has been fetched. A select input decides what happens then. The framer either closes the frame as if the packet had ended, with the check sequence when enabled and then a flag, or it sends an abort run of ones and returns to idle flags. A one-cycle status pulse marks each frame that ended because of an underrun. When the enable input is low, the framer does not drive the line. It signals this on an activity output, so that the ordinary asynchronous path can use the line.

Top module: `hdlc_tx_framer`

## Requirements
- R1: With `en` low, or during reset, the framer is inactive. From the following cycle `line_active` is 0 and `line_out` is 1, `in_ready` stays 0, and no byte is consumed.
- R2: After `en` rises, the first eight line bits are a complete flag. The flag is 0x7E sent LSB-first, giving the bit sequence 0,1,1,1,1,1,1,0. No data bit goes out before this flag is complete.
- R3: While no byte is offered, the line carries back-to-back flags and no frame appears.
- R4: Data bytes are sent LSB-first, one line bit per baud tick. A byte is fetched only on an `in_ready`/`in_valid` handshake, which occurs on the baud tick that sends the last bit of a flag or of a byte. `line_active` is 1 whenever `in_ready` is 1.
- R5: Within the data and check fields, a 0 is inserted after every five consecutive 1s. Flags and aborts are never stuffed, so outside an abort the line never carries more than six consecutive 1s.
- R6: With `crc_on` = 1, a 16-bit check sequence follows the last data byte, before the closing flag. It uses the polynomial x^16+x^12+x^5+1 in reflected form (0x8408), with a seed of all ones, and it is complemented and sent LSB-first. A receiver running the same register over data and check bytes ends at the residue 0xF0B8.
- R7: With `crc_on` = 0, no check bytes are sent and the closing flag directly follows the data.
- R8: With `urun_abort` = 0, a byte boundary reached inside a packet with no byte offered closes the frame. The check sequence is sent if enabled, then the flag.
- R9: With `urun_abort` = 1, the same underrun sends seven consecutive 1s and no check sequence. The line then returns to idle flags, and later frames are sent normally.
- R10: `urun_pulse` is a single-cycle pulse, raised once for each frame that ends through underrun, in either mode. It is never raised for a frame that ends with its end-of-packet byte, and it occurs only while `line_active` is 1.
- R11: While enabled, `line_out` changes only in the cycle after a baud tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Transmit framer enable |
| baud_tick | input | 1 | One-cycle strobe, one line bit per pulse |
| crc_on | input | 1 | Append the 16-bit check sequence |
| urun_abort | input | 1 | Underrun reaction: 0 close frame, 1 abort |
| in_data | input | 8 | Byte offered by the FIFO |
| in_valid | input | 1 | Byte on `in_data` is available |
| in_last | input | 1 | Offered byte is the last one of its packet |
| in_ready | output | 1 | Byte is taken this cycle if `in_valid` is 1 |
| line_out | output | 1 | Serial line bit (registered) |
| line_active | output | 1 | Framer owns the line (registered) |
| urun_pulse | output | 1 | Frame ended through underrun (registered) |

## Verification
The delicate coincidence is a zero-insertion that falls due on the same baud tick as a field change. This is the tick where a byte ending in five ones is followed by the check field, the closing flag, or an underrun abort. The bench provokes it with bytes such as 0xF8 and 0xFF as the last byte before a normal end, before a mode-0 underrun and before a mode-1 underrun. A bench-side deframer removes stuffed zeros, finds flags and aborts, and rebuilds the bytes. The results are judged by exact byte recovery, the check-sequence residue, the abort count and the longest run of ones seen on the line.

// File: rtl/hdlc_txf_pkg.sv
package hdlc_txf_pkg;

  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,
    ST_DATA  = 2'd1,
    ST_FCS   = 2'd2,
    ST_ABORT = 2'd3
  } txf_state_e;

  localparam logic [7:0] FLAG_BYTE = 8'h7E;

endpackage

// File: rtl/hdlc_txf_crc.sv
module hdlc_txf_crc #(
  parameter int           W    = 16,
  parameter logic [W-1:0] POLY = 16'h8408,
  parameter logic [W-1:0] SEED = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] crc
);

  logic [W-1:0] crc_q;
  logic [W-1:0] shifted;
  logic         fb;

  always_comb begin
    fb      = crc_q[0] ^ din;
    shifted = {1'b0, crc_q[W-1:1]} ^ (fb ? POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= SEED;
    end else if (step) begin
      crc_q <= shifted;
    end
  end

  assign crc = crc_q;

endmodule

// File: rtl/hdlc_txf_stuff.sv
module hdlc_txf_stuff #(
  parameter int RUN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic upd,
  input  logic bit_in,
  input  logic countable,
  output logic due
);

  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (upd) begin
      if (countable && bit_in) cnt_q <= cnt_q + CW'(1);
      else                     cnt_q <= '0;
    end
  end

  assign due = (cnt_q == CW'(RUN));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int            DATA_W    = 8,
  parameter int            CRC_W     = 16,
  parameter logic [15:0]   CRC_POLY  = 16'h8408,
  parameter int            STUFF_RUN = 5,
  parameter int            ABORT_LEN = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              baud_tick,
  input  logic              crc_on,
  input  logic              urun_abort,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              line_out,
  output logic              line_active,
  output logic              urun_pulse
);
  import hdlc_txf_pkg::*;

  localparam int MAX_A  = (CRC_W > ABORT_LEN) ? CRC_W : ABORT_LEN;
  localparam int MAXC   = (MAX_A > DATA_W) ? MAX_A : DATA_W;
  localparam int IDX_W  = $clog2(MAXC);
  localparam int BIT_W  = $clog2(DATA_W);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] LAST_FCS  = IDX_W'(CRC_W - 1);
  localparam logic [IDX_W-1:0] LAST_ABT  = IDX_W'(ABORT_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_FLAG = IDX_W'(7);

  txf_state_e        state_q, nxt_state;
  logic [IDX_W-1:0]  idx_q, nxt_idx;
  logic [DATA_W-1:0] byte_q;
  logic              last_q;
  logic              line_q, act_q, urun_q;

  logic              tick, stuff_due, need_byte, take;
  logic              emit_bit, emit_cnt, load, crc_init, crc_step, urun_set;
  logic [CRC_W-1:0]  crc_val;

  assign tick = en & baud_tick;

  hdlc_txf_stuff #(.RUN(STUFF_RUN)) u_stuff (
    .clk       (clk),
    .rst       (rst),
    .clr       (~en),
    .upd       (tick),
    .bit_in    (emit_bit),
    .countable (emit_cnt),
    .due       (stuff_due)
  );

  hdlc_txf_crc #(.W(CRC_W), .POLY(CRC_POLY[CRC_W-1:0])) u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (tick & crc_init),
    .step (tick & crc_step),
    .din  (emit_bit),
    .crc  (crc_val)
  );

  // A byte is pulled on the tick that sends the final bit of a flag or
  // of a non-final data byte.
  always_comb begin
    need_byte = 1'b0;
    if (!stuff_due) begin
      if (state_q == ST_FLAG && idx_q == LAST_FLAG) need_byte = 1'b1;
      if (state_q == ST_DATA && idx_q == LAST_BIT && !last_q) need_byte = 1'b1;
    end
  end

  assign in_ready = tick & need_byte;
  assign take     = in_ready & in_valid;

  always_comb begin
    emit_bit  = 1'b0;
    emit_cnt  = 1'b1;
    nxt_state = state_q;
    nxt_idx   = idx_q;
    load      = 1'b0;
    crc_init  = 1'b0;
    crc_step  = 1'b0;
    urun_set  = 1'b0;
    if (stuff_due) begin
      emit_bit = 1'b0;
      emit_cnt = 1'b1;
    end else begin
      unique case (state_q)
        ST_FLAG: begin
          emit_bit = FLAG_BYTE[idx_q[2:0]];
          emit_cnt = 1'b0;
          if (idx_q == LAST_FLAG) begin
            nxt_idx = '0;
            if (take) begin
              load      = 1'b1;
              crc_init  = 1'b1;
              nxt_state = ST_DATA;
            end
          end else begin
            nxt_idx = idx_q + IDX_W'(1);
          end
        end
        ST_DATA: begin
          emit_bit = byte_q[idx_q[BIT_W-1:0]];
          crc_step = 1'b1;
          if (idx_q == LAST_BIT) begin
            nxt_idx = '0;
            if (last_q) begin
              nxt_state = crc_on ? ST_FCS : ST_FLAG;
            end else if (take) begin
              load = 1'b1;
            end else begin
              urun_set  = 1'b1;
              nxt_state = urun_abort ? ST_ABORT : (crc_on ? ST_FCS : ST_FLAG);
            end
          end else begin
            nxt_idx = idx_q + IDX_W'(1);
          end
        end
        ST_FCS: begin
          emit_bit = ~crc_val[idx_q];
          if (idx_q == LAST_FCS) begin
            nxt_idx   = '0;
            nxt_state = ST_FLAG;
          end else begin
            nxt_idx = idx_q + IDX_W'(1);
          end
        end
        default: begin
          emit_bit = 1'b1;
          emit_cnt = 1'b0;
          if (idx_q == LAST_ABT) begin
            nxt_idx   = '0;
            nxt_state = ST_FLAG;
          end else begin
            nxt_idx = idx_q + IDX_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state_q <= ST_FLAG;
      idx_q   <= '0;
      byte_q  <= '0;
      last_q  <= 1'b0;
      line_q  <= 1'b1;
      act_q   <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      act_q  <= 1'b1;
      urun_q <= 1'b0;
      if (tick) begin
        line_q  <= emit_bit;
        state_q <= nxt_state;
        idx_q   <= nxt_idx;
        urun_q  <= urun_set;
        if (load) begin
          byte_q <= in_data;
          last_q <= in_last;
        end
      end
    end
  end

  assign line_out    = line_q;
  assign line_active = act_q;
  assign urun_pulse  = urun_q;

endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic baud_tick,
  input logic in_ready,
  input logic line_out,
  input logic line_active,
  input logic urun_pulse
);

  p_off_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!line_active && line_out));

  p_off_no_pull_r1: assert property (@(posedge clk) disable iff (rst)
    !en |-> !in_ready);

  p_pull_when_active_r4: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> line_active);

  p_urun_single_r10: assert property (@(posedge clk) disable iff (rst)
    urun_pulse |=> !urun_pulse);

  p_urun_active_r10: assert property (@(posedge clk) disable iff (rst)
    urun_pulse |-> line_active);

  p_line_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (en && !baud_tick) |=> $stable(line_out));

endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .baud_tick   (baud_tick),
  .in_ready    (in_ready),
  .line_out    (line_out),
  .line_active (line_active),
  .urun_pulse  (urun_pulse)
);

// File: tb/hdlc_tx_framer_bench.sv
module hdlc_tx_framer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       crc_on = 1'b0;
  logic       urun_abort = 1'b0;
  logic       baud_tick;
  logic [7:0] in_data;
  logic       in_valid, in_last, in_ready;
  logic       line_out, line_active, urun_pulse;

  always #4 clk = ~clk;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst(rst), .en(en), .baud_tick(baud_tick),
    .crc_on(crc_on), .urun_abort(urun_abort),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .in_ready(in_ready), .line_out(line_out),
    .line_active(line_active), .urun_pulse(urun_pulse)
  );

  // baud tick every second cycle
  logic tdiv = 1'b0;
  always @(posedge clk) tdiv <= ~tdiv;
  assign baud_tick = tdiv;

  // FIFO model
  int         fed = 0;
  int         feed_base = 0;
  int         feed_end = 0;
  bit         feed_last = 1'b0;
  logic [7:0] pay [0:15];
  assign in_valid = (fed < feed_end);
  assign in_data  = (fed < feed_end) ? pay[fed - feed_base] : 8'h00;
  assign in_last  = feed_last && (fed == feed_end - 1);
  always @(posedge clk) if (in_ready && in_valid) fed <= fed + 1;

  // line deframer and monitors
  int         checks = 0, fails = 0;
  int         ones = 0, nb = 0;
  int         rx_nframes = 0, rx_nbytes = 0, rx_aborts = 0, rx_flags = 0, rx_bad = 0;
  bit         bitbuf [0:2047];
  logic [7:0] rx_bytes [0:4095];
  int         rx_fstart [0:511];
  int         rx_flen [0:511];
  bit         raw_bits [0:63];
  int         raw_n = 0, run1 = 0, maxrun = 0;
  int         urun_cnt = 0, ready_off = 0, offtick = 0;
  logic       cap_q = 1'b0, prev_line = 1'b1, en_d = 1'b0;

  task automatic dec_bit(input bit b);
    int n;
    if (b) begin
      ones++;
      if (ones == 7) begin rx_aborts++; nb = 0; end
      else if (ones < 7 && nb < 2048) begin bitbuf[nb] = 1'b1; nb++; end
    end else begin
      if (ones == 5) begin
        // inserted zero, dropped
      end else if (ones == 6) begin
        n = nb - 7;
        if (n <= 0) rx_flags++;
        else if (n % 8 != 0) rx_bad++;
        else if (rx_nframes < 512) begin
          rx_fstart[rx_nframes] = rx_nbytes;
          rx_flen[rx_nframes]   = n / 8;
          for (int k = 0; k < n / 8; k++) begin
            logic [7:0] v;
            for (int i = 0; i < 8; i++) v[i] = bitbuf[8*k + i];
            if (rx_nbytes < 4096) rx_bytes[rx_nbytes] = v;
            rx_nbytes++;
          end
          rx_nframes++;
        end
        nb = 0;
      end else if (nb < 2048) begin
        bitbuf[nb] = 1'b0; nb++;
      end
      ones = 0;
    end
  endtask

  always @(posedge clk) cap_q <= baud_tick & en;

  always @(negedge clk) begin
    if (urun_pulse) urun_cnt++;
    if (!en && in_ready) ready_off++;
    if (!cap_q && en && en_d && line_out !== prev_line) offtick++;
    prev_line = line_out;
    en_d = en;
    if (cap_q) begin
      if (raw_n < 64) raw_bits[raw_n] = line_out;
      raw_n++;
      if (line_out) begin run1++; if (run1 > maxrun) maxrun = run1; end
      else run1 = 0;
      dec_bit(line_out);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] fcs_run(input int start, input int len);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int k = 0; k < len; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ rx_bytes[start + k][i];
        c  = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return c;
  endfunction

  task automatic send(input int n, input bit lst);
    @(posedge clk); #1;
    feed_base = fed;
    feed_last = lst;
    feed_end  = fed + n;
    while (fed < feed_end) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // compare frame f against pay[0..n-1], expected length n + extra
  task automatic frame_chk(input int f, input int n, input int extra,
                           input bit want_fcs, input string tag);
    int errs;
    errs = 0;
    chk(rx_flen[f] == n + extra, tag, rx_flen[f], n + extra);
    for (int i = 0; i < n; i++)
      if (rx_bytes[rx_fstart[f] + i] !== pay[i]) errs++;
    chk(errs == 0, tag, errs, 0);
    if (want_fcs)
      chk(fcs_run(rx_fstart[f], rx_flen[f]) == 16'hF0B8, "R6 residue",
          int'(fcs_run(rx_fstart[f], rx_flen[f])), 'hF0B8);
  endtask

  initial begin
    int f0, u0, a0, fl0, errs_len, errs_byte, errs_fcs;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(line_active == 1'b0, "R1 reset active", line_active, 0);
    chk(line_out == 1'b1, "R1 reset line", line_out, 1);
    chk(urun_pulse == 1'b0, "R10 reset pulse", urun_pulse, 0);

    // R1: disabled, byte offered
    @(posedge clk); #1;
    pay[0] = 8'hA5; feed_base = fed; feed_last = 1'b1; feed_end = fed + 1;
    idle(40);
    chk(ready_off == 0, "R1 ready while off", ready_off, 0);
    chk(fed == 0, "R1 bytes taken while off", fed, 0);
    chk(line_active == 1'b0 && line_out == 1'b1, "R1 line while off", line_out, 1);

    // R2: enable, first flag then the pending frame
    @(posedge clk); #1;
    crc_on = 1'b1; en = 1'b1;
    while (fed < feed_end) @(negedge clk);
    idle(150);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 8; i++) if (raw_bits[i] !== ((8'h7E >> i) & 1)) bad++;
      chk(bad == 0, "R2 opening flag bits", bad, 0);
    end
    chk(rx_nframes == 1, "R2 first frame", rx_nframes, 1);
    frame_chk(0, 1, 2, 1'b1, "R4 first frame bytes");

    // R3: idle flags
    f0 = rx_nframes; fl0 = rx_flags;
    idle(100);
    chk(rx_nframes == f0, "R3 no frame while idle", rx_nframes, f0);
    chk(rx_flags - fl0 >= 5, "R3 idle flags", rx_flags - fl0, 5);

    // R4/R6: every byte value as a one-byte frame with check sequence
    f0 = rx_nframes; u0 = urun_cnt;
    for (int v = 0; v < 256; v++) begin
      pay[0] = v[7:0];
      send(1, 1'b1);
    end
    idle(150);
    chk(rx_nframes - f0 == 256, "R4 sweep frame count", rx_nframes - f0, 256);
    errs_len = 0; errs_byte = 0; errs_fcs = 0;
    for (int v = 0; v < 256; v++) begin
      int f;
      f = f0 + v;
      if (f < 512) begin
        if (rx_flen[f] != 3) errs_len++;
        if (rx_bytes[rx_fstart[f]] !== v[7:0]) errs_byte++;
        if (fcs_run(rx_fstart[f], rx_flen[f]) != 16'hF0B8) errs_fcs++;
      end
    end
    chk(errs_len == 0, "R6 sweep length with check bytes", errs_len, 0);
    chk(errs_byte == 0, "R4 sweep byte values", errs_byte, 0);
    chk(errs_fcs == 0, "R6 sweep residue", errs_fcs, 0);
    chk(urun_cnt == u0, "R10 no pulse on normal end", urun_cnt - u0, 0);
    chk(rx_bad == 0, "R5 misaligned frames", rx_bad, 0);

    // R5/R7: stuffing at byte and field edges, no check sequence
    crc_on = 1'b0;
    pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'h3E; pay[4] = 8'hF8;
    f0 = rx_nframes;
    send(5, 1'b1);
    idle(150);
    chk(rx_nframes - f0 == 1, "R5 stuffed frame count", rx_nframes - f0, 1);
    frame_chk(f0, 5, 0, 1'b0, "R5 stuffed bytes");
    chk(maxrun <= 6, "R5 longest ones run", maxrun, 6);

    // R7: lengths 1..8 without check bytes
    for (int n = 1; n <= 8; n++) begin
      for (int i = 0; i < n; i++) pay[i] = 8'((n * 37 + i * 11) & 255);
      pay[n-1] = 8'hF8;
      f0 = rx_nframes;
      send(n, 1'b1);
      idle(120);
      chk(rx_nframes - f0 == 1, "R7 frame present", rx_nframes - f0, 1);
      frame_chk(f0, n, 0, 1'b0, "R7 plain frame bytes");
    end

    // R8: underrun closes the frame, check sequence on
    crc_on = 1'b1; urun_abort = 1'b0;
    pay[0] = 8'h11; pay[1] = 8'h22; pay[2] = 8'hF8;
    f0 = rx_nframes; u0 = urun_cnt; a0 = rx_aborts;
    send(3, 1'b0);
    idle(150);
    chk(rx_nframes - f0 == 1, "R8 closed frame count", rx_nframes - f0, 1);
    frame_chk(f0, 3, 2, 1'b1, "R8 closed frame bytes");
    chk(urun_cnt - u0 == 1, "R10 pulse mode 0", urun_cnt - u0, 1);
    chk(rx_aborts == a0, "R8 no abort", rx_aborts - a0, 0);

    // R8: underrun closes the frame, check sequence off
    crc_on = 1'b0;
    f0 = rx_nframes; u0 = urun_cnt;
    send(3, 1'b0);
    idle(150);
    chk(rx_nframes - f0 == 1, "R8 closed plain count", rx_nframes - f0, 1);
    frame_chk(f0, 3, 0, 1'b0, "R8 closed plain bytes");
    chk(urun_cnt - u0 == 1, "R10 pulse mode 0 plain", urun_cnt - u0, 1);

    chk(offtick == 0, "R11 change without tick", offtick, 0);
    chk(maxrun <= 6, "R5 longest ones run before abort", maxrun, 6);

    // R9: underrun aborts
    crc_on = 1'b1; urun_abort = 1'b1;
    f0 = rx_nframes; u0 = urun_cnt; a0 = rx_aborts;
    send(3, 1'b0);
    idle(150);
    chk(rx_aborts - a0 == 1, "R9 abort seen", rx_aborts - a0, 1);
    chk(rx_nframes == f0, "R9 no frame from abort", rx_nframes - f0, 0);
    chk(urun_cnt - u0 == 1, "R10 pulse mode 1", urun_cnt - u0, 1);
    pay[0] = 8'h5A;
    send(1, 1'b1);
    idle(150);
    chk(rx_nframes - f0 == 1, "R9 frame after abort", rx_nframes - f0, 1);
    frame_chk(f0, 1, 2, 1'b1, "R9 frame after abort bytes");
    chk(urun_cnt - u0 == 1, "R10 no pulse after abort frame", urun_cnt - u0, 1);

    // R1: disable again
    @(posedge clk); #1 en = 1'b0;
    idle(10);
    chk(line_active == 1'b0 && line_out == 1'b1, "R1 disabled again", line_active, 0);
    chk(offtick == 0, "R11 change without tick at end", offtick, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule